// File: doc/BRIEF.md
# Serial Flash Command Control Logic

This block is the command side of a serial flash slave. It works in SPI mode 0 with one data bit in each direction. The SPI pins are sampled by a system clock through synchronizers. Bits on the serial input are taken on rising serial-clock edges, most significant bit first, while chip select is low. The first byte of a frame is the opcode, and later bytes are only counted.

A write-enable latch gates every command that would change the memory content. An accepted content-changing command raises a busy flag for a fixed number of system clocks. When busy falls, the latch clears itself.

The identification command shifts out three bytes on the serial output. The output changes on falling serial-clock edges. An output-enable signal stands in for the high-impedance state.

The serial pins carry no valid/ready stream. The master controls the pace alone through the serial clock, and the block never applies back-pressure. The master must keep each serial-clock phase at least `SYNC_STAGES+2` system clocks long.

Top module: `sflash_cmd_ctrl`

## Requirements
- R1: A frame that holds exactly the single byte 0x06 and ends on a byte boundary sets `wel`.
- R2: A frame that holds exactly the single byte 0x04 and ends on a byte boundary clears `wel`.
- R3: A content-changing command starts busy only if `wel` is set when chip select rises. The commands and their byte counts are:
  - 0x60 and 0xC7: exactly 1 byte.
  - 0x01: exactly 2 bytes.
  - 0x20, 0x52 and 0xD8: exactly 4 bytes.
  - 0x02 and 0x38: at least 5 bytes.
  - 0xAD: at least 6 bytes.
- R4: A frame whose byte count does not fit its command, or that ends part-way through a byte, is discarded and leaves `wel` unchanged.
- R5: `busy` stays high for exactly `BUSY_CYCLES` system clocks, and `wel` is low from the cycle in which `busy` falls.
- R6: After the opcode 0x9F, the output presents 0xC2, then 0x25, then `DEV_ID`, MSB first. Each bit is updated after a falling serial-clock edge, with `so_oe` high while a bit is driven. Once the 24 bits have been shifted out, the next falling edge drops `so_oe`.
- R7: Raising chip select during the ID output ends it at once (`so_oe` low), and the next 0x9F frame starts again from the first byte.
- R8: While `busy` is high, every frame is ignored: 0x9F produces no output and 0x06 does not set `wel`.
- R9: After reset, `wel`, `busy` and `so_oe` are low.
- R10: Any other opcode has no effect on `wel` or `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, meaningful when `so_oe` is high |
| so_oe | output | 1 | Output enable for `so` |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Program or erase in progress |

## Verification
The bench builds the block with `BUSY_CYCLES` set to 600 and `DEV_ID` set to 0x5A. A busy window of 600 clocks is long enough to send whole frames while busy is high, which brings the ignore rule for identification and write-enable within reach. The distinct ID byte shows that the parameter reaches the output.

Every one of the 256 opcodes is swept as a one-byte frame with the latch already set. Byte counts from one to seven are swept for the fixed-length and minimum-length commands, and a frame that ends part-way through a byte is also sent.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int BYTE_W  = 8;
  localparam int BCNT_W  = 3;
  localparam int ID_BITS = 24;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam logic [7:0] ID_MFR  = 8'hC2;
  localparam logic [7:0] ID_TYPE = 8'h25;

  typedef enum logic [1:0] {K_NONE, K_WREN, K_WRDI, K_MOD} kind_e;

  typedef struct packed {
    kind_e             kind;
    logic              exact;
    logic [BCNT_W-1:0] need;
  } cmd_t;

  function automatic cmd_t decode(input logic [7:0] op);
    cmd_t c;
    c = '{kind: K_NONE, exact: 1'b1, need: 3'd1};
    case (op)
      OP_WREN:       c.kind = K_WREN;
      OP_WRDI:       c.kind = K_WRDI;
      8'h60, 8'hC7:  c.kind = K_MOD;
      8'h01:         c = '{kind: K_MOD, exact: 1'b1, need: 3'd2};
      8'h20, 8'h52,
      8'hD8:         c = '{kind: K_MOD, exact: 1'b1, need: 3'd4};
      8'h02, 8'h38:  c = '{kind: K_MOD, exact: 1'b0, need: 3'd5};
      8'hAD:         c = '{kind: K_MOD, exact: 1'b0, need: 3'd6};
      default:       c.kind = K_NONE;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else prev <= stg[STAGES-1];
  end

  assign q    = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev;
  assign fall = ~stg[STAGES-1] & prev;
endmodule

// File: rtl/sfc_rx.sv
module sfc_rx
  import sfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi,
  input  logic              smp,
  input  logic              si_s,
  output logic              byte_done,
  output logic [7:0]        byte_val,
  output logic [7:0]        opcode,
  output logic [BCNT_W-1:0] nbytes,
  output logic              aligned
);
  logic [7:0] sh;
  logic [2:0] bit_cnt;
  logic [7:0] nxt;

  assign nxt     = {sh[6:0], si_s};
  assign aligned = (bit_cnt == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; bit_cnt <= '0; nbytes <= '0;
      byte_done <= 1'b0; byte_val <= '0; opcode <= '0;
    end else if (cs_hi) begin
      bit_cnt <= '0; nbytes <= '0; byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (smp) begin
        sh      <= nxt;
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          byte_val  <= nxt;
          if (nbytes == '0) opcode <= nxt;
          if (nbytes != '1) nbytes <= nbytes + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sfc_tx.sv
module sfc_tx
  import sfc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_hi,
  input  logic               arm,
  input  logic               shift,
  input  logic [ID_BITS-1:0] id,
  output logic               so,
  output logic               so_oe
);
  localparam int LW = $clog2(ID_BITS + 1);
  logic [ID_BITS-1:0] sh;
  logic [LW-1:0]      left;
  logic               armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; left <= '0; armed <= 1'b0; so <= 1'b0; so_oe <= 1'b0;
    end else if (cs_hi) begin
      armed <= 1'b0; left <= '0; so <= 1'b0; so_oe <= 1'b0;
    end else if (arm) begin
      armed <= 1'b1;
      sh    <= id;
      left  <= LW'(ID_BITS);
    end else if (armed && shift) begin
      if (left != '0) begin
        so    <= sh[ID_BITS-1];
        sh    <= sh << 1;
        so_oe <= 1'b1;
        left  <= left - 1'b1;
      end else begin
        so    <= 1'b0;
        so_oe <= 1'b0;
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sflash_cmd_ctrl.sv
module sflash_cmd_ctrl
  import sfc_pkg::*;
#(
  parameter logic [7:0] DEV_ID = 8'h36,
  parameter int BUSY_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic si,
  output logic so,
  output logic so_oe,
  output logic wel,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [2:0] s_q, s_rise, s_fall;
  logic cs_s, cs_rise, sclk_rise, sclk_fall, si_s;

  sfc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, si}),
    .q(s_q), .rise(s_rise), .fall(s_fall)
  );
  assign cs_s      = s_q[2];
  assign cs_rise   = s_rise[2];
  assign sclk_rise = s_rise[1] & ~cs_s;
  assign sclk_fall = s_fall[1] & ~cs_s;
  assign si_s      = s_q[0];

  logic              byte_done, aligned;
  logic [7:0]        byte_val, opcode;
  logic [BCNT_W-1:0] nbytes;

  sfc_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_s), .smp(sclk_rise), .si_s(si_s),
    .byte_done(byte_done), .byte_val(byte_val), .opcode(opcode),
    .nbytes(nbytes), .aligned(aligned)
  );

  logic rdid_arm;
  assign rdid_arm = byte_done && (nbytes == 3'd1) && (byte_val == OP_RDID) && !busy;

  sfc_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_s), .arm(rdid_arm), .shift(sclk_fall),
    .id({ID_MFR, ID_TYPE, DEV_ID}), .so(so), .so_oe(so_oe)
  );

  cmd_t cmd;
  logic count_ok;
  assign cmd      = decode(opcode);
  assign count_ok = cmd.exact ? (nbytes == cmd.need) : (nbytes >= cmd.need);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0; busy <= 1'b0; cnt <= '0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end
    end else if (cs_rise && aligned && nbytes != '0) begin
      case (cmd.kind)
        K_WREN: if (nbytes == 3'd1) wel <= 1'b1;
        K_WRDI: if (nbytes == 3'd1) wel <= 1'b0;
        K_MOD:  if (wel && count_ok) begin
                  busy <= 1'b1;
                  cnt  <= CW'(BUSY_CYCLES);
                end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sflash_cmd_ctrl_chk.sv
module sflash_cmd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic so,
  input logic so_oe,
  input logic wel,
  input logic busy
);
  // R3
  busy_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  // R5
  wel_clear_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  // R8
  no_id_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> !busy);
  // R8
  no_wren_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(busy));
  // R7
  oe_off_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);
  // R6
  so_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !so_oe |-> !so);
endmodule

bind sflash_cmd_ctrl sflash_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so(so),
  .so_oe(so_oe), .wel(wel), .busy(busy)
);

// File: tb/sflash_cmd_ctrl_bench.sv
module sflash_cmd_ctrl_bench;
  localparam int BUSY = 600;
  localparam logic [7:0] DEV = 8'h5A;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, si = 0;
  logic so, so_oe, wel, busy;
  int errs = 0, checks = 0, busy_seen = 0;
  logic oe_seen;
  logic [7:0] rx;

  always #4 clk = ~clk;

  sflash_cmd_ctrl #(.DEV_ID(DEV), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u_sflash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
    .so(so), .so_oe(so_oe), .wel(wel), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input int n, input logic [7:0] v);
    for (int i = 7; i > 7 - n; i--) begin
      si = v[i];
      clks(HALF);
      rx = {rx[6:0], so};
      if (so_oe) oe_seen = 1;
      sclk = 1;
      clks(HALF);
      sclk = 0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 0; oe_seen = 0; clks(HALF);
  endtask

  task automatic cs_hi(input bit wait_idle);
    clks(HALF);
    cs_n = 1;
    busy_seen = 0;
    for (int i = 0; i < 10; i++) begin clks(1); if (busy) busy_seen++; end
    if (wait_idle)
      for (int i = 0; i < BUSY + 50 && busy; i++) begin clks(1); if (busy) busy_seen++; end
  endtask

  task automatic frame(input logic [7:0] op, input int n);
    cs_lo();
    bits(8, op);
    for (int i = 1; i < n; i++) bits(8, 8'h00);
    cs_hi(1);
  endtask

  task automatic rdid_check(input string req);
    cs_lo();
    bits(8, 8'h9F);
    bits(8, 8'h00); chk(req, rx, 8'hC2);
    bits(8, 8'h00); chk(req, rx, 8'h25);
    bits(8, 8'h00); chk(req, rx, DEV);
    clks(HALF); chk(req, so_oe, 0);
    cs_hi(1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    clks(5); rst_n = 1; clks(5);
    // R9 reset state
    chk("R9", wel, 0); chk("R9", busy, 0); chk("R9", so_oe, 0);

    // Sweep all opcodes as single-byte frames with WEL set (R1 R2 R3 R5 R10)
    for (int op = 0; op < 256; op++) begin
      frame(8'h06, 1);
      chk("R1", wel, 1);
      frame(op[7:0], 1);
      if (op == 8'h04) begin
        chk("R2", wel, 0); chk("R2", busy_seen, 0);
      end else if (op == 8'h60 || op == 8'hC7) begin
        chk("R5", busy_seen, BUSY); chk("R5", wel, 0);
      end else begin
        chk("R10", wel, 1); chk("R10", busy_seen, 0);
      end
      frame(8'h04, 1);
    end

    // Byte count sweeps (R3 R4)
    for (int n = 1; n <= 7; n++) begin
      frame(8'h06, 1); frame(8'h20, n);
      chk("R3", busy_seen, (n == 4) ? BUSY : 0); chk("R4", wel, (n == 4) ? 0 : 1);
      frame(8'h04, 1);
      frame(8'h06, 1); frame(8'h02, n);
      chk("R3", busy_seen, (n >= 5) ? BUSY : 0); chk("R4", wel, (n >= 5) ? 0 : 1);
      frame(8'h04, 1);
      frame(8'h06, 1); frame(8'hAD, n);
      chk("R3", busy_seen, (n >= 6) ? BUSY : 0);
      frame(8'h04, 1);
      frame(8'h06, 1); frame(8'h01, n);
      chk("R3", busy_seen, (n == 2) ? BUSY : 0);
      frame(8'h04, 1);
    end

    // R3 no WEL: program refused
    frame(8'h02, 5); chk("R3", busy_seen, 0); chk("R3", wel, 0);

    // R4 misaligned end
    frame(8'h06, 1);
    cs_lo(); bits(8, 8'h20); for (int i = 0; i < 3; i++) bits(8, 8'h00); bits(3, 8'h00); cs_hi(1);
    chk("R4", busy_seen, 0); chk("R4", wel, 1);
    cs_lo(); bits(5, 8'h04); cs_hi(1);
    chk("R4", wel, 1);
    frame(8'h04, 1);

    // R6 ID output
    rdid_check("R6");
    // R7 abort mid-ID, then restart
    cs_lo(); bits(8, 8'h9F); bits(8, 8'h00); bits(4, 8'h00);
    chk("R7", so_oe, 1);
    cs_hi(0); chk("R7", so_oe, 0);
    rdid_check("R7");

    // R8 ignored while busy
    frame(8'h06, 1);
    cs_lo(); bits(8, 8'hC7); cs_hi(0);
    chk("R8", busy, 1);
    cs_lo(); bits(8, 8'h9F); bits(8, 8'h00); bits(8, 8'h00);
    chk("R8", oe_seen, 0);
    cs_hi(0);
    cs_lo(); bits(8, 8'h06); cs_hi(0);
    chk("R8", busy, 1);
    cs_lo(); cs_hi(1);
    chk("R8", busy, 0); chk("R8", wel, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule